// File: doc/BRIEF.md
# DMA block transfer count unit

This unit keeps the counters of one DMA channel that moves data in fixed-size blocks. Software loads three registers over a small synchronous write port: a block-size holding value, a per-unit counter that tracks the units left in the current block, and a block counter that tracks the blocks left in the whole job. The channel's transfer engine pulses `unit_done` once for every byte or word it moves.

Each accepted pulse lowers the unit counter by one. When a pulse arrives while the unit counter stands at one, the block is complete. In that cycle the unit counter is refilled from the holding value, the block counter steps down by one and `blk_boundary` is raised. When that step takes the block counter from one to zero, `xfer_end` rises in the same cycle. It then stays high, and it blocks all counting until software pulses `arm`.

Top module: `dma_blk_count_unit`

## Requirements
- R1: After reset, the holding value, the unit counter and the block counter all read zero, `xfer_end` reads 1 and `blk_boundary` reads 0.
- R2: A write with `wr_en`=1 loads the register selected by `wr_sel`: 0 loads the holding value from `wr_data[7:0]`, 1 loads the unit counter from `wr_data[7:0]`, 2 loads the block counter from `wr_data[15:0]`, and 3 loads both the holding value and the unit counter from `wr_data[7:0]`. The new value appears on the readback outputs one cycle later.
- R3: An accepted `unit_done` pulse lowers the unit counter by one. The new value is visible on the next cycle.
- R4: A pulse accepted while the unit counter is 1 raises `blk_boundary` combinationally in that same cycle. On the next cycle the unit counter holds the holding value.
- R5: Each block boundary lowers the block counter by one.
- R6: The boundary that takes the block counter from 1 to 0 raises `xfer_end` in that same cycle. `xfer_end` stays 1 afterwards.
- R7: While `xfer_end` is set, `unit_done` is ignored: no counter changes and `blk_boundary` stays 0. An `arm` pulse clears `xfer_end`.
- R8: A register write takes priority. A `unit_done` pulse in the same cycle as a write is dropped entirely, and no counter other than the written one changes.
- R9: A counter value of zero stands for its full range. A unit counter at 0 steps to 255 with no boundary. A boundary with the block counter at 0 leaves it at 65535, and `xfer_end` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| unit_done | input | 1 | One unit transferred |
| arm | input | 1 | Clears the end flag |
| size_hold_o | output | 8 | Holding value readback |
| unit_cnt_o | output | 8 | Unit counter readback |
| blk_cnt_o | output | 16 | Block counter readback |
| blk_boundary | output | 1 | Block completed this cycle |
| xfer_end | output | 1 | Whole transfer finished |

## Verification
`blk_boundary` and the rising edge of `xfer_end` are combinational on the accepted pulse. The bench therefore samples them in the same cycle, shortly after it drives `unit_done` on the falling edge. The counter readbacks and the cleared state after `arm` come from registers and are due one edge later. The bench reads them at the following falling edge. Every write, pulse and arm is driven for one cycle, so each sample can be traced to one stimulus.

// File: rtl/dma_blk_count_pkg.sv
package dma_blk_count_pkg;
  localparam int unsigned UNIT_W = 8;
  localparam int unsigned BLK_W  = 16;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_HOLD = 2'd0,
    SEL_UNIT = 2'd1,
    SEL_BLK  = 2'd2,
    SEL_BOTH = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hold,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  input  logic         step,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] hold_d;
  logic [W-1:0] cnt_d;
  logic         at_one;

  assign at_one = (cnt_q == ONE);
  assign wrap   = step & at_one;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (wr_hold) hold_d = wr_data;
    if (wr_cnt) begin
      cnt_d = wr_data;
    end else if (step) begin
      cnt_d = at_one ? hold_q : (cnt_q - ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_hold)        hold_q <= hold_d;
      if (wr_cnt || step) cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/dma_block_counter.sv
module dma_block_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         step,
  output logic [W-1:0] cnt_q,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;

  assign last = step & (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (wr)        cnt_d = wr_data;
    else if (step) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (wr || step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma_end_flag.sv
module dma_end_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic end_q
);
  logic end_d;

  always_comb begin
    end_d = end_q;
    if (set)      end_d = 1'b1;
    else if (clr) end_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) end_q <= 1'b1;
    else        end_q <= end_d;
  end
endmodule

// File: rtl/dma_blk_count_unit.sv
module dma_blk_count_unit
  import dma_blk_count_pkg::*;
#(
  parameter int unsigned UW = UNIT_W,
  parameter int unsigned BW = BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [BW-1:0] wr_data,
  input  logic          unit_done,
  input  logic          arm,
  output logic [UW-1:0] size_hold_o,
  output logic [UW-1:0] unit_cnt_o,
  output logic [BW-1:0] blk_cnt_o,
  output logic          blk_boundary,
  output logic          xfer_end
);
  wr_sel_e sel;
  logic    wr_hold, wr_unit, wr_blk;
  logic    accept, wrap, last, end_q;

  assign sel     = wr_sel_e'(wr_sel);
  assign wr_hold = wr_en & ((sel == SEL_HOLD) | (sel == SEL_BOTH));
  assign wr_unit = wr_en & ((sel == SEL_UNIT) | (sel == SEL_BOTH));
  assign wr_blk  = wr_en & (sel == SEL_BLK);
  assign accept  = unit_done & ~end_q & ~wr_en;

  dma_unit_counter #(.W(UW)) u_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hold (wr_hold),
    .wr_cnt  (wr_unit),
    .wr_data (wr_data[UW-1:0]),
    .step    (accept),
    .hold_q  (size_hold_o),
    .cnt_q   (unit_cnt_o),
    .wrap    (wrap)
  );

  dma_block_counter #(.W(BW)) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_blk),
    .wr_data (wr_data),
    .step    (wrap),
    .cnt_q   (blk_cnt_o),
    .last    (last)
  );

  dma_end_flag u_end (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (last),
    .clr   (arm),
    .end_q (end_q)
  );

  assign blk_boundary = wrap;
  assign xfer_end     = end_q | last;
endmodule

// File: rtl/dma_blk_count_checker.sv
module dma_blk_count_checker #(
  parameter int unsigned UW = 8,
  parameter int unsigned BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [BW-1:0] wr_data,
  input logic          unit_done,
  input logic          arm,
  input logic [UW-1:0] size_hold_o,
  input logic [UW-1:0] unit_cnt_o,
  input logic [BW-1:0] blk_cnt_o,
  input logic          blk_boundary,
  input logic          xfer_end,
  input logic          end_q
);
  p_unit_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> unit_cnt_o == $past(wr_data[UW-1:0]));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_boundary |=> unit_cnt_o == $past(size_hold_o));

  p_blk_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_boundary |=> blk_cnt_o == $past(blk_cnt_o) - 1'b1);

  p_end_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !arm) |=> end_q);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !wr_en) |=> ($stable(unit_cnt_o) && $stable(blk_cnt_o)));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !blk_boundary);

  p_bnd_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_boundary |-> (unit_done && unit_cnt_o == UW'(1)));
endmodule

bind dma_blk_count_unit dma_blk_count_checker #(.UW(UW), .BW(BW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .unit_done    (unit_done),
  .arm          (arm),
  .size_hold_o  (size_hold_o),
  .unit_cnt_o   (unit_cnt_o),
  .blk_cnt_o    (blk_cnt_o),
  .blk_boundary (blk_boundary),
  .xfer_end     (xfer_end),
  .end_q        (end_q)
);

// File: tb/dma_blk_count_unit_test.sv
`timescale 1ns/1ps
module dma_blk_count_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, unit_done, arm;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [7:0]  size_hold_o, unit_cnt_o;
  logic [15:0] blk_cnt_o;
  logic        blk_boundary, xfer_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_blk_count_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .unit_done(unit_done), .arm(arm),
    .size_hold_o(size_hold_o), .unit_cnt_o(unit_cnt_o),
    .blk_cnt_o(blk_cnt_o), .blk_boundary(blk_boundary), .xfer_end(xfer_end)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // one pulse; checks combinational outputs in the same cycle
  task automatic pulse(input string req, input logic exp_bnd, input logic exp_end);
    @(negedge clk);
    unit_done = 1'b1;
    #1;
    chk(req, "blk_boundary", {15'd0, blk_boundary}, {15'd0, exp_bnd});
    chk(req, "xfer_end", {15'd0, xfer_end}, {15'd0, exp_end});
    @(negedge clk);
    unit_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "size_hold", {8'd0, size_hold_o}, 16'd0);
    chk("R1", "unit_cnt", {8'd0, unit_cnt_o}, 16'd0);
    chk("R1", "blk_cnt", blk_cnt_o, 16'd0);
    chk("R1", "xfer_end", {15'd0, xfer_end}, 16'd1);
    chk("R1", "blk_boundary", {15'd0, blk_boundary}, 16'd0);
  endtask

  task automatic t_writes();
    do_write(2'd0, 16'h0005);
    chk("R2", "hold sel0", {8'd0, size_hold_o}, 16'h05);
    do_write(2'd1, 16'hAB03);
    chk("R2", "unit sel1", {8'd0, unit_cnt_o}, 16'h03);
    chk("R2", "hold untouched", {8'd0, size_hold_o}, 16'h05);
    do_write(2'd2, 16'h1234);
    chk("R2", "blk sel2", blk_cnt_o, 16'h1234);
    do_write(2'd3, 16'h0007);
    chk("R2", "hold sel3", {8'd0, size_hold_o}, 16'h07);
    chk("R2", "unit sel3", {8'd0, unit_cnt_o}, 16'h07);
  endtask

  task automatic t_end_blocks();
    pulse("R7", 1'b0, 1'b1);
    chk("R7", "unit frozen", {8'd0, unit_cnt_o}, 16'h07);
    chk("R7", "blk frozen", blk_cnt_o, 16'h1234);
  endtask

  task automatic t_basic();
    do_write(2'd3, 16'h0003);
    do_write(2'd2, 16'h0002);
    do_arm();
    chk("R7", "arm clears", {15'd0, xfer_end}, 16'd0);
    pulse("R3", 1'b0, 1'b0);
    chk("R3", "unit 3->2", {8'd0, unit_cnt_o}, 16'd2);
    pulse("R3", 1'b0, 1'b0);
    chk("R3", "unit 2->1", {8'd0, unit_cnt_o}, 16'd1);
    pulse("R4", 1'b1, 1'b0);
    chk("R4", "reload", {8'd0, unit_cnt_o}, 16'd3);
    chk("R5", "blk 2->1", blk_cnt_o, 16'd1);
    pulse("R3", 1'b0, 1'b0);
    pulse("R3", 1'b0, 1'b0);
    pulse("R6", 1'b1, 1'b1);
    chk("R6", "blk 1->0", blk_cnt_o, 16'd0);
    chk("R4", "reload last", {8'd0, unit_cnt_o}, 16'd3);
    chk("R6", "end sticky", {15'd0, xfer_end}, 16'd1);
    pulse("R7", 1'b0, 1'b1);
    chk("R7", "unit frozen", {8'd0, unit_cnt_o}, 16'd3);
    chk("R7", "blk frozen", blk_cnt_o, 16'd0);
  endtask

  task automatic t_priority();
    do_write(2'd3, 16'h0004);
    do_write(2'd2, 16'h0005);
    do_arm();
    @(negedge clk);
    unit_done = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h0009;
    #1;
    chk("R8", "no boundary", {15'd0, blk_boundary}, 16'd0);
    @(negedge clk);
    unit_done = 1'b0; wr_en = 1'b0;
    chk("R8", "blk written", blk_cnt_o, 16'h0009);
    chk("R8", "unit untouched", {8'd0, unit_cnt_o}, 16'd4);
  endtask

  task automatic t_zero();
    do_write(2'd3, 16'h0000);
    do_write(2'd2, 16'h0000);
    pulse("R9", 1'b0, 1'b0);
    chk("R9", "unit 0->255", {8'd0, unit_cnt_o}, 16'h00FF);
    do_write(2'd3, 16'h0001);
    pulse("R9", 1'b1, 1'b0);
    chk("R9", "blk 0->FFFF", blk_cnt_o, 16'hFFFF);
    chk("R9", "end stays 0", {15'd0, xfer_end}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    unit_done = 1'b0; arm = 1'b0;
    #9 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_end_blocks();
    t_basic();
    t_priority();
    t_zero();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule